// File: doc/BRIEF.md
# Dual-Port Synchronous RAM Core

A true dual-port static memory with two fully independent ports, A and B, each running on its own clock. Either port may read or write any word at any time, including the word the other port is touching in the same cycle. Every input of a port (address, write data, byte enables, write strobe, both selects and the read-mode strap) is captured on the rising edge of that port's clock. The access itself takes place in the cycle after capture.

Each port carries a pair of selects of opposite polarity. The port is active only when the low-true select is sampled low and the high-true select is sampled high. A port that is not selected makes no access and keeps its read output frozen. Words are split into byte lanes, and each lane is written only when its byte-enable bit is set. A per-port strap chooses between a flow-through read path, where data appears in the cycle after capture, and a registered read path, which adds one more register stage. Storage is built from two single-writer banks, and a per-lane tag table records which bank holds the newest copy of each lane. No storage element is written from two clock domains.

Top module: `dpram_core`

## Requirements
- R1: After reset both read outputs are zero in either read mode.
- R2: A write captured on a rising edge is returned by a read of that address captured on any later edge, on either port.
- R3: With the mode strap at 1 (registered), read data for a read captured at edge k appears on the output after edge k+1 and stays until edge k+2.
- R4: With the mode strap at 0 (flow-through), read data for a read captured at edge k appears on the output right after edge k.
- R5: A port is active only if its low-true select is 0 and its high-true select is 1 at the edge. Otherwise its write strobe, address and data are ignored, and no word changes.
- R6: Byte-enable bit i gates word bits [i*LANE_W +: LANE_W]. A cleared bit leaves that lane of the stored word unchanged.
- R7: When both ports write the same address in the same cycle, port A's data wins in each lane that both enable, and port B's data is kept in lanes only B enables.
- R8: A read on one port of an address that the other port writes in the same cycle returns the data held before that write.
- R9: The read output holds its last read value through cycles in which the port is deselected or writing.
- R10: Both ports serve different addresses in the same cycle without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Port A clock |
| clk_b_i | input | 1 | Port B clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_cs_n_i | input | 1 | Port A low-true select |
| a_cs_i | input | 1 | Port A high-true select |
| a_we_i | input | 1 | Port A write strobe (1 write, 0 read) |
| a_be_i | input | LANES | Port A byte-lane enables |
| a_addr_i | input | AW | Port A word address |
| a_wdata_i | input | LANES*LANE_W | Port A write data |
| a_pipe_i | input | 1 | Port A read mode (1 registered, 0 flow-through) |
| a_rdata_o | output | LANES*LANE_W | Port A read data |
| b_cs_n_i | input | 1 | Port B low-true select |
| b_cs_i | input | 1 | Port B high-true select |
| b_we_i | input | 1 | Port B write strobe |
| b_be_i | input | LANES | Port B byte-lane enables |
| b_addr_i | input | AW | Port B word address |
| b_wdata_i | input | LANES*LANE_W | Port B write data |
| b_pipe_i | input | 1 | Port B read mode |
| b_rdata_o | output | LANES*LANE_W | Port B read data |

## Verification
The bench builds the core with AW=4, LANES=2 and LANE_W=9. This gives an 18-bit word with two 9-bit lanes, so the parity-width lane split is exercised on every write. With only sixteen words, the bench can fill the whole array and read it back in a few dozen cycles. Both port clocks come from one source, so same-edge collisions between the ports can be produced on purpose and their outcome checked exactly.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

  typedef enum logic {
    RD_FLOW = 1'b0,
    RD_PIPE = 1'b1
  } rd_mode_e;

  // port is live only with low-true select low and high-true select high
  function automatic logic port_live(input logic sel_n, input logic sel);
    return !sel_n && sel;
  endfunction

endpackage

// File: rtl/dpram_req_reg.sv
module dpram_req_reg
  import dpram_pkg::*;
#(
  parameter int AW     = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              pipe_i,
  output logic              rd_o,
  output logic              wr_o,
  output logic [LANES-1:0]  be_o,
  output logic [AW-1:0]     addr_o,
  output logic [DW-1:0]     wdata_o,
  output logic              pipe_o
);

  logic live;
  assign live = port_live(cs_n_i, cs_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_o    <= 1'b0;
      wr_o    <= 1'b0;
      be_o    <= '0;
      addr_o  <= '0;
      wdata_o <= '0;
      pipe_o  <= 1'b0;
    end else begin
      rd_o   <= live && !we_i;
      wr_o   <= live && we_i;
      pipe_o <= pipe_i;
      // idle port keeps its last request fields to save toggling
      if (live) begin
        be_o    <= be_i;
        addr_o  <= addr_i;
        wdata_o <= wdata_i;
      end
    end
  end

endmodule

// File: rtl/dpram_bank.sv
module dpram_bank #(
  parameter int AW     = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W,
  localparam int DEPTH = 1 << AW
) (
  input  logic              clk_i,
  input  logic [LANES-1:0]  wen_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [LANES-1:0]  wtag_i,
  input  logic [AW-1:0]     raddr0_i,
  input  logic [AW-1:0]     raddr1_i,
  output logic [DW-1:0]     rdata0_o,
  output logic [DW-1:0]     rdata1_o,
  output logic [LANES-1:0]  rtag0_o,
  output logic [LANES-1:0]  rtag1_o,
  input  logic [AW-1:0]     xaddr_i,
  output logic [LANES-1:0]  xtag_o
);

  logic [DW-1:0]    mem   [DEPTH];
  logic [LANES-1:0] tag_t [DEPTH];

  // single writer: only this bank's own port clock touches mem and tag_t
  always_ff @(posedge clk_i) begin
    for (int l = 0; l < LANES; l++) begin
      if (wen_i[l]) begin
        mem[waddr_i][l*LANE_W +: LANE_W] <= wdata_i[l*LANE_W +: LANE_W];
        tag_t[waddr_i][l]                <= wtag_i[l];
      end
    end
  end

  assign rdata0_o = mem[raddr0_i];
  assign rdata1_o = mem[raddr1_i];
  assign rtag0_o  = tag_t[raddr0_i];
  assign rtag1_o  = tag_t[raddr1_i];
  assign xtag_o   = tag_t[xaddr_i];

endmodule

// File: rtl/dpram_rd_path.sv
module dpram_rd_path
  import dpram_pkg::*;
#(
  parameter int DW = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic          pipe_i,
  input  logic [DW-1:0] arr_i,
  output logic [DW-1:0] flow_o,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] hold_q;

  // flow value falls back to the held word when no read is in flight
  assign flow_o = rd_i ? arr_i : hold_q;

  // hold_q doubles as the registered-mode output stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= '0;
    else         hold_q <= flow_o;
  end

  assign rdata_o = (rd_mode_e'(pipe_i) == RD_PIPE) ? hold_q : flow_o;

endmodule

// File: rtl/dpram_core.sv
module dpram_core
  import dpram_pkg::*;
#(
  parameter int AW     = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic              clk_a_i,
  input  logic              clk_b_i,
  input  logic              rst_ni,
  input  logic              a_cs_n_i,
  input  logic              a_cs_i,
  input  logic              a_we_i,
  input  logic [LANES-1:0]  a_be_i,
  input  logic [AW-1:0]     a_addr_i,
  input  logic [DW-1:0]     a_wdata_i,
  input  logic              a_pipe_i,
  output logic [DW-1:0]     a_rdata_o,
  input  logic              b_cs_n_i,
  input  logic              b_cs_i,
  input  logic              b_we_i,
  input  logic [LANES-1:0]  b_be_i,
  input  logic [AW-1:0]     b_addr_i,
  input  logic [DW-1:0]     b_wdata_i,
  input  logic              b_pipe_i,
  output logic [DW-1:0]     b_rdata_o
);

  localparam int NP = 2;

  logic [NP-1:0]            clk, cs_n, cs, we, pipe_in;
  logic [NP-1:0][LANES-1:0] be_in;
  logic [NP-1:0][AW-1:0]    addr_in;
  logic [NP-1:0][DW-1:0]    wdata_in;

  assign clk      = {clk_b_i,   clk_a_i};
  assign cs_n     = {b_cs_n_i,  a_cs_n_i};
  assign cs       = {b_cs_i,    a_cs_i};
  assign we       = {b_we_i,    a_we_i};
  assign pipe_in  = {b_pipe_i,  a_pipe_i};
  assign be_in    = {b_be_i,    a_be_i};
  assign addr_in  = {b_addr_i,  a_addr_i};
  assign wdata_in = {b_wdata_i, a_wdata_i};

  logic [NP-1:0]            rd_q, wr_q, pipe_q;
  logic [NP-1:0][LANES-1:0] be_q;
  logic [NP-1:0][AW-1:0]    addr_q;
  logic [NP-1:0][DW-1:0]    wdata_q;

  logic [NP-1:0][LANES-1:0] wen, new_tag, xtag;
  logic [LANES-1:0]         coll;

  // bank_dat[bank][reader], bank_tag[bank][reader]
  logic [NP-1:0][NP-1:0][DW-1:0]    bank_dat;
  logic [NP-1:0][NP-1:0][LANES-1:0] bank_tag;

  logic [NP-1:0][DW-1:0] arr_rd, flow_d, rdata;

  for (genvar p = 0; p < NP; p++) begin : g_port
    dpram_req_reg #(
      .AW     (AW),
      .LANES  (LANES),
      .LANE_W (LANE_W)
    ) u_req (
      .clk_i   (clk[p]),
      .rst_ni  (rst_ni),
      .cs_n_i  (cs_n[p]),
      .cs_i    (cs[p]),
      .we_i    (we[p]),
      .be_i    (be_in[p]),
      .addr_i  (addr_in[p]),
      .wdata_i (wdata_in[p]),
      .pipe_i  (pipe_in[p]),
      .rd_o    (rd_q[p]),
      .wr_o    (wr_q[p]),
      .be_o    (be_q[p]),
      .addr_o  (addr_q[p]),
      .wdata_o (wdata_q[p]),
      .pipe_o  (pipe_q[p])
    );

    dpram_bank #(
      .AW     (AW),
      .LANES  (LANES),
      .LANE_W (LANE_W)
    ) u_bank (
      .clk_i    (clk[p]),
      .wen_i    (wen[p]),
      .waddr_i  (addr_q[p]),
      .wdata_i  (wdata_q[p]),
      .wtag_i   (new_tag[p]),
      .raddr0_i (addr_q[0]),
      .raddr1_i (addr_q[1]),
      .rdata0_o (bank_dat[p][0]),
      .rdata1_o (bank_dat[p][1]),
      .rtag0_o  (bank_tag[p][0]),
      .rtag1_o  (bank_tag[p][1]),
      .xaddr_i  (addr_q[NP-1-p]),
      .xtag_o   (xtag[p])
    );

    dpram_rd_path #(
      .DW (DW)
    ) u_rd (
      .clk_i   (clk[p]),
      .rst_ni  (rst_ni),
      .rd_i    (rd_q[p]),
      .pipe_i  (pipe_q[p]),
      .arr_i   (arr_rd[p]),
      .flow_o  (flow_d[p]),
      .rdata_o (rdata[p])
    );

    // lane newest copy: tags equal -> bank 0, tags differ -> bank 1
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign arr_rd[p][l*LANE_W +: LANE_W] =
        (bank_tag[0][p][l] ^ bank_tag[1][p][l]) ? bank_dat[1][p][l*LANE_W +: LANE_W]
                                                : bank_dat[0][p][l*LANE_W +: LANE_W];
    end
  end

  // A makes tags equal, B makes them differ
  assign new_tag[0] = xtag[1];
  assign new_tag[1] = ~xtag[0];

  // same-edge collision: port B yields every lane port A also writes
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      coll[l] = wr_q[0] && wr_q[1] && (addr_q[0] == addr_q[1]) && be_q[0][l] && be_q[1][l];
      wen[0][l] = wr_q[0] && be_q[0][l];
      wen[1][l] = wr_q[1] && be_q[1][l] && !coll[l];
    end
  end

  assign a_rdata_o = rdata[0];
  assign b_rdata_o = rdata[1];

endmodule

// File: rtl/dpram_core_chk.sv
module dpram_core_chk #(
  parameter int AW     = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input logic                  clk_a_i,
  input logic                  clk_b_i,
  input logic                  rst_ni,
  input logic                  a_cs_n_i,
  input logic                  a_cs_i,
  input logic                  b_cs_n_i,
  input logic                  b_cs_i,
  input logic [DW-1:0]         a_rdata_o,
  input logic [DW-1:0]         b_rdata_o,
  input logic [1:0]            rd_q,
  input logic [1:0]            wr_q,
  input logic [1:0]            pipe_q,
  input logic [1:0][LANES-1:0] be_q,
  input logic [1:0][AW-1:0]    addr_q,
  input logic [1:0][LANES-1:0] wen,
  input logic [1:0][DW-1:0]    flow_d
);

  p_idle_no_req_a_r5: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (a_cs_n_i || !a_cs_i) |=> !(rd_q[0] || wr_q[0]));

  p_idle_no_req_b_r5: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (b_cs_n_i || !b_cs_i) |=> !(rd_q[1] || wr_q[1]));

  p_pipe_lag_a_r3: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    pipe_q[0] |-> a_rdata_o == $past(flow_d[0]));

  p_pipe_lag_b_r3: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    pipe_q[1] |-> b_rdata_o == $past(flow_d[1]));

  p_flow_hold_a_r9: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (!pipe_q[0] && !rd_q[0] && $past(!pipe_q[0])) |-> $stable(a_rdata_o));

  p_flow_hold_b_r9: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (!pipe_q[1] && !rd_q[1] && $past(!pipe_q[1])) |-> $stable(b_rdata_o));

  // collision recomputed from the request registers
  p_a_wins_r7: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (wr_q[0] && wr_q[1] && addr_q[0] == addr_q[1]) |-> ((wen[1] & be_q[0]) == '0));

  p_no_write_idle_r5: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    !wr_q[0] |-> (wen[0] == '0));

endmodule

bind dpram_core dpram_core_chk #(
  .AW     (AW),
  .LANES  (LANES),
  .LANE_W (LANE_W)
) u_chk (
  .clk_a_i   (clk_a_i),
  .clk_b_i   (clk_b_i),
  .rst_ni    (rst_ni),
  .a_cs_n_i  (a_cs_n_i),
  .a_cs_i    (a_cs_i),
  .b_cs_n_i  (b_cs_n_i),
  .b_cs_i    (b_cs_i),
  .a_rdata_o (a_rdata_o),
  .b_rdata_o (b_rdata_o),
  .rd_q      (rd_q),
  .wr_q      (wr_q),
  .pipe_q    (pipe_q),
  .be_q      (be_q),
  .addr_q    (addr_q),
  .wen       (wen),
  .flow_d    (flow_d)
);

// File: tb/dpram_core_test.sv
`timescale 1ns/1ps
module dpram_core_test;
  localparam int AW = 4, LANES = 2, LANE_W = 9, DW = LANES*LANE_W, DEPTH = 1 << AW;

  typedef struct {
    logic          cs_n;
    logic          cs;
    logic          we;
    logic [1:0]    be;
    int            addr;
    logic [DW-1:0] wd;
  } op_t;

  typedef struct {
    int            due;
    int            port;
    logic [DW-1:0] exp;
    string         tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic a_cs_n = 1, a_cs = 0, a_we = 0, a_pipe = 0, b_cs_n = 1, b_cs = 0, b_we = 0, b_pipe = 0;
  logic [LANES-1:0] a_be = '0, b_be = '0;
  logic [AW-1:0]    a_addr = '0, b_addr = '0;
  logic [DW-1:0]    a_wd = '0, b_wd = '0, a_rd, b_rd;

  dpram_core #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) uut (
    .clk_a_i(clk), .clk_b_i(clk), .rst_ni(rst_n),
    .a_cs_n_i(a_cs_n), .a_cs_i(a_cs), .a_we_i(a_we), .a_be_i(a_be), .a_addr_i(a_addr),
    .a_wdata_i(a_wd), .a_pipe_i(a_pipe), .a_rdata_o(a_rd),
    .b_cs_n_i(b_cs_n), .b_cs_i(b_cs), .b_we_i(b_we), .b_be_i(b_be), .b_addr_i(b_addr),
    .b_wdata_i(b_wd), .b_pipe_i(b_pipe), .b_rdata_o(b_rd)
  );

  int cyc = 0, n_chk = 0, n_fail = 0;
  bit done = 0;
  exp_t sb[$];
  logic [DW-1:0] model [DEPTH];
  logic [DW-1:0] last [2];
  bit pmode [2];

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare every expectation due in this cycle
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        logic [DW-1:0] got;
        got = sb[i].port == 0 ? a_rd : b_rd;
        n_chk++;
        if (got !== sb[i].exp) begin
          n_fail++;
          $display("FAIL %s port %0d: got %h expected %h", sb[i].tag, sb[i].port, got, sb[i].exp);
        end
        sb.delete(i);
      end
    end
  end

  function automatic op_t idle();
    op_t o = '{1'b1, 1'b0, 1'b0, 2'b00, 0, '0};
    return o;
  endfunction
  function automatic op_t rd(int addr);
    op_t o = '{1'b0, 1'b1, 1'b0, 2'b00, addr, '0};
    return o;
  endfunction
  function automatic op_t wr(int addr, logic [DW-1:0] d, logic [1:0] be);
    op_t o = '{1'b0, 1'b1, 1'b1, be, addr, d};
    return o;
  endfunction

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] d, logic [1:0] be);
    logic [DW-1:0] r = old;
    for (int l = 0; l < LANES; l++)
      if (be[l]) r[l*LANE_W +: LANE_W] = d[l*LANE_W +: LANE_W];
    return r;
  endfunction

  // driver: apply one cycle on both ports and push expected outputs
  task automatic step(op_t a, op_t b, string tag);
    op_t ops [2];
    @(negedge clk);
    ops[0] = a; ops[1] = b;
    a_cs_n = a.cs_n; a_cs = a.cs; a_we = a.we; a_be = a.be; a_addr = AW'(a.addr); a_wd = a.wd; a_pipe = pmode[0];
    b_cs_n = b.cs_n; b_cs = b.cs; b_we = b.we; b_be = b.be; b_addr = AW'(b.addr); b_wd = b.wd; b_pipe = pmode[1];
    for (int p = 0; p < 2; p++) begin
      exp_t e;
      if (!ops[p].cs_n && ops[p].cs && !ops[p].we) last[p] = model[ops[p].addr];
      e.due = cyc + (pmode[p] ? 2 : 1); e.port = p; e.exp = last[p]; e.tag = tag;
      sb.push_back(e);
    end
    // B first so that A overwrites shared lanes
    for (int p = 1; p >= 0; p--)
      if (!ops[p].cs_n && ops[p].cs && ops[p].we)
        model[ops[p].addr] = merge(model[ops[p].addr], ops[p].wd, ops[p].be);
  endtask

  task automatic set_modes(bit ma, bit mb);
    repeat (2) step(idle(), idle(), "R9 drain");
    pmode[0] = ma; pmode[1] = mb;
    repeat (2) step(idle(), idle(), "R9 mode switch hold");
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    last[0] = '0; last[1] = '0; pmode[0] = 0; pmode[1] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    n_chk++;
    if (a_rd !== '0 || b_rd !== '0) begin
      n_fail++;
      $display("FAIL R1 reset: got %h/%h expected 0", a_rd, b_rd);
    end

    // R2 R4: fill the array through A, flow-through mode
    for (int i = 0; i < DEPTH; i++) step(wr(i, DW'(18'h2A5A5 ^ (i * 18'h0111)), 2'b11), idle(), "R2 fill");
    for (int i = 0; i < DEPTH; i++) step(rd(i), rd(DEPTH-1-i), "R4 R10 flow readback");

    // R8 read while the other port writes the same word
    step(wr(3, 18'h15555, 2'b11), rd(3), "R8 old data on B");
    step(idle(), rd(3), "R2 new data on B");
    step(rd(9), wr(9, 18'h0F0F0, 2'b11), "R8 old data on A");
    step(rd(9), idle(), "R2 new data on A");

    // R7 same-word writes
    step(wr(5, 18'h3FE01, 2'b01), wr(5, 18'h00A55, 2'b11), "R7 split lanes");
    step(rd(5), rd(5), "R7 split lanes readback");
    step(wr(6, 18'h12345, 2'b11), wr(6, 18'h2BCDE, 2'b11), "R7 full collision");
    step(rd(6), rd(6), "R7 full collision readback");

    // R6 byte lanes
    step(wr(7, 18'h3FFFF, 2'b10), wr(8, 18'h3FFFF, 2'b01), "R6 lane write");
    step(rd(7), rd(8), "R6 lane readback");
    step(wr(7, 18'h00000, 2'b00), idle(), "R6 no lanes");
    step(rd(7), idle(), "R6 no lanes readback");

    // R5 R9 deselected writes change nothing, output holds
    step(rd(10), rd(11), "R9 load");
    step('{1'b1, 1'b1, 1'b1, 2'b11, 10, 18'h00001}, '{1'b0, 1'b0, 1'b1, 2'b11, 11, 18'h00002}, "R5 R9 deselect write");
    step('{1'b0, 1'b0, 1'b0, 2'b11, 12, '0}, wr(13, 18'h3C3C3, 2'b11), "R9 hold while writing");
    step(rd(10), rd(11), "R5 deselect readback");

    // R3 registered read path
    set_modes(1, 1);
    for (int i = 0; i < 6; i++) step(rd(i), rd(i + 6), "R3 pipe read");
    step(wr(2, 18'h0ABCD, 2'b11), idle(), "R9 pipe hold");
    step(idle(), rd(2), "R3 R2 pipe cross port");
    step(rd(2), wr(4, 18'h11111, 2'b01), "R3 R6 pipe");
    step(rd(4), rd(4), "R3 R6 pipe readback");

    // mixed modes on the two ports
    set_modes(0, 1);
    for (int i = 0; i < 4; i++) step(rd(15 - i), rd(i), "R3 R4 mixed modes");
    set_modes(0, 0);
    repeat (3) step(idle(), idle(), "R9 final hold");
    repeat (3) @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule